// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem status byte of a 16550-style serial port. Four modem input lines (clear-to-send, data-set-ready, carrier-detect and ring) pass through a synchroniser. Their current levels are held in the upper nibble of the byte. Sticky change flags are held in the lower nibble, and the interrupt logic receives a change indication that stays high while any flag is set. The block also holds the 5-bit modem control register, because loopback mode takes the status from those control outputs.

Software reads the byte with a one-cycle read strobe. The read data is combinational and shows the value that holds during the strobe cycle. In normal mode the strobe clears the change flags at the next clock edge. A change that reaches the flags on that same edge is kept. In loopback mode the read data is built from the control register, and a read leaves the flags untouched.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status byte reads 0xB0 (carrier, data-set-ready and clear-to-send levels high, ring low, no flags set), the control register reads 0x08 (only OUT2 set) and the change indication is low.
- R2: Each modem input reaches the upper nibble on the third rising clock edge after it changes (two synchroniser stages plus the level register). Earlier reads still show the old level.
- R3: A change of carrier-detect, data-set-ready or clear-to-send in either direction sets its flag at bit 3, bit 1 or bit 0. Several lines that change together set all of their flags on the same edge.
- R4: The ring flag at bit 2 is set only when the ring level falls from 1 to 0. A rise from 0 to 1 leaves it clear.
- R5: In normal mode a read strobe returns the full byte and clears all four flags at the next clock edge.
- R6: A line change whose flag would be set on the same edge at which a read clears the flags sets that flag anyway.
- R7: With the loop bit (control bit 4) set, the read data is OUT2 (control bit 3) in bit 7, OUT1 (control bit 2) in bit 6, DTR (control bit 0) in bit 5, RTS (control bit 1) in bit 4, and zeros in bits 3:0. A read in this mode does not clear the flags.
- R8: The control register loads its 5-bit write data on a clock edge with the write enable high, and holds its value otherwise.
- R9: The change indication is high exactly while at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cts_pin | input | 1 | Clear-to-send line, asynchronous |
| dsr_pin | input | 1 | Data-set-ready line, asynchronous |
| dcd_pin | input | 1 | Carrier-detect line, asynchronous |
| ri_pin | input | 1 | Ring line, asynchronous |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 5 | Control register write data: loop, OUT2, OUT1, RTS, DTR from bit 4 down to bit 0 |
| ctl_q | output | 5 | Current control register value |
| stat_rd | input | 1 | Status byte read strobe, one cycle per read |
| stat_rdata | output | 8 | Status byte read data, valid during the strobe cycle |
| stat_change | output | 1 | High while any change flag is set |

## Verification
Assertions check on every cycle that the ring flag rises only together with a falling ring level, and that a level difference at the synchroniser output sets the matching flag on the next edge. They also check that a normal-mode read with no pending change leaves every flag clear, that flags stay set until a normal-mode read, and that the control register loads and holds as specified. Only the bench's scenarios show the three-cycle latency from the pins, the exact loopback mapping for several control values, a line change that meets a read on the same edge, and that the flags survive a loopback read and reappear when loopback is turned off.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES   = 4;
  localparam int CTL_W   = 5;
  localparam int BYTE_W  = 8;
  // Line index inside a nibble; the same index is used for level and flag.
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;
  // Control register bit positions.
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
  localparam logic [LINES-1:0] LVL_RST = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;
  // Lines whose flag is set on any change; the ring line uses a falling edge.
  localparam logic [LINES-1:0] ANY_EDGE_MASK = 4'b1011;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/msr_track.sv
module msr_track
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] smp,
  input  logic             clr,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] flag
);
  logic [LINES-1:0] lvl_nx;
  logic [LINES-1:0] flag_nx;
  logic [LINES-1:0] edge_hit;

  always_comb begin
    edge_hit = (lvl ^ smp) & ANY_EDGE_MASK;
    edge_hit[L_RI] = lvl[L_RI] & ~smp[L_RI];
    lvl_nx  = smp;
    flag_nx = (clr ? '0 : flag) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= LVL_RST;
      flag <= '0;
    end else begin
      lvl  <= lvl_nx;
      flag <= flag_nx;
    end
  end

  assert_ri_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[L_RI]) |-> $fell(lvl[L_RI]));

  assert_dsr_change_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp[L_DSR] != lvl[L_DSR]) |=> flag[L_DSR]);

  assert_dcd_change_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp[L_DCD] != lvl[L_DCD]) |=> flag[L_DCD]);

  assert_cts_change_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp[L_CTS] != lvl[L_CTS]) |=> flag[L_CTS]);

  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && smp == lvl) |=> (flag == '0));

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flag & $past(flag)) == $past(flag)));

  assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl == $past(smp)));
endmodule

// File: rtl/msr_ctl_reg.sv
module msr_ctl_reg
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] q
);
  logic [CTL_W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (we) q_nx = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= CTL_RST;
    else        q <= q_nx;
  end

  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));

  assert_ctl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/msr_view.sv
module msr_view
  import msr_pkg::*;
(
  input  logic [CTL_W-1:0]  ctl,
  input  logic [LINES-1:0]  lvl,
  input  logic [LINES-1:0]  flag,
  output logic [BYTE_W-1:0] rdata
);
  logic [LINES-1:0] loop_lvl;

  always_comb begin
    loop_lvl        = '0;
    loop_lvl[L_DCD] = ctl[C_OUT2];
    loop_lvl[L_RI]  = ctl[C_OUT1];
    loop_lvl[L_DSR] = ctl[C_DTR];
    loop_lvl[L_CTS] = ctl[C_RTS];
    if (ctl[C_LOOP]) rdata = {loop_lvl, {LINES{1'b0}}};
    else             rdata = {lvl, flag};
  end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_pin,
  input  logic              dsr_pin,
  input  logic              dcd_pin,
  input  logic              ri_pin,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_q,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] stat_rdata,
  output logic              stat_change
);
  logic [LINES-1:0] pins_raw;
  logic [LINES-1:0] pins_smp;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] flag;
  logic             rd_clr;

  always_comb begin
    pins_raw        = '0;
    pins_raw[L_CTS] = cts_pin;
    pins_raw[L_DSR] = dsr_pin;
    pins_raw[L_RI]  = ri_pin;
    pins_raw[L_DCD] = dcd_pin;
  end

  msr_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_smp)
  );

  msr_ctl_reg u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .q     (ctl_q)
  );

  assign rd_clr = stat_rd & ~ctl_q[C_LOOP];

  msr_track u_track (
    .clk   (clk),
    .rst_n (rst_n),
    .smp   (pins_smp),
    .clr   (rd_clr),
    .lvl   (lvl),
    .flag  (flag)
  );

  msr_view u_view (
    .ctl   (ctl_q),
    .lvl   (lvl),
    .flag  (flag),
    .rdata (stat_rdata)
  );

  assign stat_change = |flag;

  assert_loop_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[C_LOOP] |-> (stat_rdata[3:0] == 4'h0));

  assert_loop_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_change && ctl_q[C_LOOP]) |=> stat_change);
endmodule

// File: tb/tb_modem_status_unit.sv
module tb_modem_status_unit;
  localparam int CLK_P = 10;

  logic       clk;
  logic       rst_n;
  logic       cts, dsr, dcd, ri;
  logic       ctl_we;
  logic [4:0] ctl_wdata;
  logic [4:0] ctl_q;
  logic       stat_rd;
  logic [7:0] stat_rdata;
  logic       stat_change;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  modem_status_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cts_pin(cts), .dsr_pin(dsr), .dcd_pin(dcd), .ri_pin(ri),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .stat_change(stat_change)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  // Behavioural reference: pin history queue, status levels, flags, control.
  logic [3:0] hist[$];
  logic [3:0] m_lvl;
  logic [3:0] m_flg;
  logic [4:0] m_ctl;

  function automatic logic [7:0] expect_rd();
    if (m_ctl[4]) return {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'h0};
    return {m_lvl, m_flg};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = 4'b1011;
      m_flg = 4'h0;
      m_ctl = 5'h08;
      hist.delete();
      hist.push_back(4'b1011);
      hist.push_back(4'b1011);
    end else begin
      logic [3:0] nl;
      logic [3:0] f;
      nl = hist.pop_front();
      hist.push_back({dcd, ri, dsr, cts});
      f = m_flg;
      if (stat_rd && !m_ctl[4]) f = 4'h0;
      for (int b = 0; b < 4; b++) begin
        if (b == 2) begin
          if (m_lvl[2] && !nl[2]) f[2] = 1'b1;
        end else if (m_lvl[b] != nl[b]) f[b] = 1'b1;
      end
      m_lvl = nl;
      m_flg = f;
      if (ctl_we) m_ctl = ctl_wdata;
    end
  end

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model, an eighth of a period after each edge.
  always @(posedge clk) begin
    #(CLK_P/8);
    if (rst_n && !done) begin
      check8(m_ctl[4] ? "R7 loopback read data" : "R2 status byte", stat_rdata, expect_rd());
      check8("R8 control register", {3'b0, ctl_q}, {3'b0, m_ctl});
      check8("R9 change indication", {7'b0, stat_change}, {7'b0, (m_flg != 4'h0)});
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_P/8);
  endtask

  task automatic set_pins(logic c_dcd, logic c_ri, logic c_dsr, logic c_cts);
    @(negedge clk);
    dcd = c_dcd; ri = c_ri; dsr = c_dsr; cts = c_cts;
  endtask

  task automatic do_read();
    @(negedge clk);
    stat_rd = 1;
    tick();
    @(negedge clk);
    stat_rd = 0;
  endtask

  task automatic write_ctl(logic [4:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v;
    tick();
    @(negedge clk);
    ctl_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 0; stat_rd = 0; ctl_we = 0; ctl_wdata = 5'h0;
    dcd = 1; ri = 0; dsr = 1; cts = 1;
    #(CLK_P*3);
    check8("R1 reset status", stat_rdata, 8'hB0);
    check8("R1 reset control", {3'b0, ctl_q}, 8'h08);
    check8("R1 reset change", {7'b0, stat_change}, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (3) tick();

    // R2/R3: clear-to-send falls, visible on third edge.
    set_pins(1, 0, 1, 0);
    tick(); tick();
    check8("R2 old level before latency", stat_rdata, 8'hB0);
    tick();
    check8("R3 cts fall sets flag", stat_rdata, 8'hA1);
    check8("R9 change high", {7'b0, stat_change}, 8'h01);

    // R5: read returns byte and clears flags.
    @(negedge clk); stat_rd = 1; #1;
    check8("R5 read data during strobe", stat_rdata, 8'hA1);
    tick();
    check8("R5 flags cleared", stat_rdata, 8'hA0);
    check8("R9 change low after clear", {7'b0, stat_change}, 8'h00);
    @(negedge clk); stat_rd = 0;

    // R4: ring rise sets nothing, fall sets flag.
    set_pins(1, 1, 1, 0);
    repeat (3) tick();
    check8("R4 ring rise no flag", stat_rdata, 8'hE0);
    set_pins(1, 0, 1, 0);
    repeat (3) tick();
    check8("R4 ring fall sets flag", stat_rdata, 8'hA4);

    // R6: read clears while a new change lands on the same edge.
    set_pins(1, 0, 0, 0);
    tick(); tick();
    @(negedge clk); stat_rd = 1;
    tick();
    check8("R6 change kept during read", stat_rdata, 8'h82);
    @(negedge clk); stat_rd = 0;

    // R7/R8: loopback mappings.
    write_ctl(5'h13);
    check8("R8 control loaded", {3'b0, ctl_q}, 8'h13);
    check8("R7 loop DTR RTS", stat_rdata, 8'h30);
    do_read();
    check8("R7 loop read keeps flags", {7'b0, stat_change}, 8'h01);
    write_ctl(5'h1C);
    check8("R7 loop OUT2 OUT1", stat_rdata, 8'hC0);
    write_ctl(5'h1A);
    check8("R7 loop OUT2 RTS", stat_rdata, 8'h90);
    write_ctl(5'h00);
    check8("R7 flags back after loop off", stat_rdata, 8'h82);

    // R3: several lines together.
    set_pins(0, 0, 1, 1);
    repeat (3) tick();
    check8("R3 multi-line change", stat_rdata, 8'h3B);
    do_read();
    check8("R5 multi clear", stat_rdata, 8'h30);

    // R1: reset again mid-run.
    @(negedge clk); rst_n = 0; #1;
    check8("R1 re-reset status", stat_rdata, 8'hB0);
    check8("R1 re-reset control", {3'b0, ctl_q}, 8'h08);
    check8("R1 re-reset change", {7'b0, stat_change}, 8'h00);
    @(negedge clk); rst_n = 1;
    repeat (5) tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule